// File: doc/BRIEF.md
# Signed Multiply-Accumulate Accumulator

This block holds a 64-bit signed accumulator and feeds it from a 16x16 signed multiplier. On each clock where the operation strobe is high, it carries out one operation on the accumulator:

- Multiply: the product replaces the accumulator.
- Multiply-accumulate: the product is added to the accumulator.

Both the multiply and the multiply-accumulate come in a form that takes the upper 16-bit halves of the two 32-bit operands and a form that takes the lower halves. The 32-bit product is sign-extended and shifted left by 16 before it is used, so that its least significant bit lines up with accumulator bit 16.

The remaining operations:

- Rounding: shifts the accumulator left by one or two places and adds one half of the low word. It then clamps the result to a 48-bit signed range and zeroes the low 32 bits.
- Writes: load the upper or the lower 32-bit half of the accumulator from operand A.
- Reads: copy one of three 32-bit windows of the accumulator into a registered result.

Every operation takes one clock. The effect on the accumulator or on the read result is visible in the cycle after the strobe.

Top module: `mac_acc_unit`

## Requirements
- R1: After reset the accumulator is zero and `rd_data` is zero.
- R2: Op codes 1 (upper halves) and 2 (lower halves) replace the accumulator with the product of the two selected 16-bit fields, both taken as signed. The product is sign-extended to 64 bits and shifted left by 16. The unselected halves have no effect.
- R3: Op codes 3 (upper halves) and 4 (lower halves) add the same aligned product to the accumulator. The sum wraps modulo 2^64.
- R4: Op code 5 rounds. It shifts the accumulator left by 2 when `rnd_shift` is 2 and by 1 for any other value of `rnd_shift`. It then adds 0x0000_0000_8000_0000.
- R5: After the rounding add, the signed value is clamped. A value above 0x0000_7FFF_0000_0000 becomes that value, and a value below 0xFFFF_8000_0000_0000 becomes that value.
- R6: After the clamp, rounding leaves accumulator bits 31:0 at zero.
- R7: Op code 6 loads accumulator bits 63:32 from `opnd_a`, and op code 7 loads bits 31:0 from `opnd_a`. In both cases the other half keeps its value.
- R8: Op codes 8, 9 and 10 load `rd_data` with accumulator bits 63:32, 47:16 and 31:0 respectively. A read does not change the accumulator.
- R9: With `op_valid` low, or with op code 0 or 11 to 15, neither the accumulator nor `rd_data` changes. `rd_data` also holds its value through every operation other than a read.
- R10: Every operation takes effect at the next rising clock edge. A read issued in the cycle after a write or an accumulate returns the updated value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 4 | Operation select (see R2 to R9) |
| opnd_a | input | 32 | First operand; write data for op codes 6 and 7 |
| opnd_b | input | 32 | Second operand |
| rnd_shift | input | 2 | Left shift used by rounding (2 gives 2, otherwise 1) |
| rd_data | output | 32 | Registered read result |

## Verification
The bench drives the following corner cases:

- Products of the most negative half-words. A design that treated the fields as unsigned, or forgot the 16-bit alignment, would return a wrong upper or middle window.
- Accumulation across the signed 64-bit boundary. This exposes a saturating or truncated adder.
- Rounding at the exact clamp limits, just past them, and in both directions with either shift. Errors here show up as an off-by-one ceiling, a missing floor, or a low word that is not cleared.
- Shift codes 0 and 3. An implementation that passed the raw `rnd_shift` through would shift by the wrong amount.
- Undefined op codes and a low strobe, each followed by reads. This would catch a block that decoded too loosely.

// File: rtl/mac_pkg.sv
package mac_pkg;

    typedef enum logic [3:0] {
        OP_NONE   = 4'd0,
        OP_MUL_HI = 4'd1,
        OP_MUL_LO = 4'd2,
        OP_MAC_HI = 4'd3,
        OP_MAC_LO = 4'd4,
        OP_ROUND  = 4'd5,
        OP_WR_HI  = 4'd6,
        OP_WR_LO  = 4'd7,
        OP_RD_HI  = 4'd8,
        OP_RD_MID = 4'd9,
        OP_RD_LO  = 4'd10
    } mac_op_e;

endpackage

// File: rtl/mac_mult.sv
// Signed half-word multiplier with product alignment into the accumulator.
module mac_mult #(
    parameter int OP_W   = 32,
    parameter int HALF_W = 16,
    parameter int ACC_W  = 64,
    parameter int ALIGN  = 16
) (
    input  logic             sel_hi,
    input  logic [OP_W-1:0]  opnd_a,
    input  logic [OP_W-1:0]  opnd_b,
    output logic [ACC_W-1:0] prod
);
    localparam int PROD_W = 2 * HALF_W;
    localparam int EXT_W  = ACC_W - PROD_W;

    logic signed [HALF_W-1:0] half_a;
    logic signed [HALF_W-1:0] half_b;
    logic signed [PROD_W-1:0] raw;
    logic        [ACC_W-1:0]  wide;

    always_comb begin
        half_a = sel_hi ? opnd_a[OP_W-1 -: HALF_W] : opnd_a[HALF_W-1:0];
        half_b = sel_hi ? opnd_b[OP_W-1 -: HALF_W] : opnd_b[HALF_W-1:0];
        raw    = half_a * half_b;
        wide   = {{EXT_W{raw[PROD_W-1]}}, raw};
        prod   = wide << ALIGN;
    end

endmodule

// File: rtl/mac_round.sv
// Shift, add half of the low word, clamp to the saturation range, clear the low word.
module mac_round #(
    parameter int ACC_W = 64,
    parameter int LOW_W = 32,
    parameter int SAT_W = 48
) (
    input  logic [ACC_W-1:0] acc_in,
    input  logic [1:0]       shift_sel,
    output logic [ACC_W-1:0] acc_out
);
    localparam logic [ACC_W-1:0] ONE      = ACC_W'(1);
    localparam logic [ACC_W-1:0] HALF_LSB = ONE << (LOW_W - 1);
    localparam logic [ACC_W-1:0] LOW_MASK = (ONE << LOW_W) - ONE;
    localparam logic [ACC_W-1:0] SAT_MAX  = ((ONE << (SAT_W - 1)) - ONE) & ~LOW_MASK;
    localparam logic [ACC_W-1:0] SAT_MIN  = ~((ONE << (SAT_W - 1)) - ONE);

    logic [ACC_W-1:0] shifted;
    logic [ACC_W-1:0] summed;
    logic [ACC_W-1:0] clamped;

    always_comb begin
        shifted = (shift_sel == 2'd2) ? (acc_in << 2) : (acc_in << 1);
        summed  = shifted + HALF_LSB;
        if ($signed(summed) > $signed(SAT_MAX)) begin
            clamped = SAT_MAX;
        end else if ($signed(summed) < $signed(SAT_MIN)) begin
            clamped = SAT_MIN;
        end else begin
            clamped = summed;
        end
        acc_out = clamped & ~LOW_MASK;
    end

endmodule

// File: rtl/mac_acc_unit.sv
module mac_acc_unit
    import mac_pkg::*;
#(
    parameter int OP_W   = 32,
    parameter int HALF_W = 16,
    parameter int ACC_W  = 64,
    parameter int SAT_W  = 48
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [3:0]      op_code,
    input  logic [OP_W-1:0] opnd_a,
    input  logic [OP_W-1:0] opnd_b,
    input  logic [1:0]      rnd_shift,
    output logic [OP_W-1:0] rd_data
);
    localparam int MID_LSB = (ACC_W - OP_W) / 2;
    localparam int ALIGN   = HALF_W;
    localparam logic [ACC_W-1:0] ONE    = ACC_W'(1);
    localparam logic [ACC_W-1:0] LIM_HI = ((ONE << (SAT_W - 1)) - ONE) & ~((ONE << OP_W) - ONE);
    localparam logic [ACC_W-1:0] LIM_LO = ~((ONE << (SAT_W - 1)) - ONE);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [OP_W-1:0]  rd;
    } mac_state_t;

    mac_state_t       st_d, st_q;
    logic             mul_hi_sel;
    logic [ACC_W-1:0] prod;
    logic [ACC_W-1:0] rounded;

    assign mul_hi_sel = (op_code == OP_MUL_HI) || (op_code == OP_MAC_HI);

    mac_mult #(
        .OP_W  (OP_W),
        .HALF_W(HALF_W),
        .ACC_W (ACC_W),
        .ALIGN (ALIGN)
    ) u_mult (
        .sel_hi(mul_hi_sel),
        .opnd_a(opnd_a),
        .opnd_b(opnd_b),
        .prod  (prod)
    );

    mac_round #(
        .ACC_W(ACC_W),
        .LOW_W(OP_W),
        .SAT_W(SAT_W)
    ) u_round (
        .acc_in   (st_q.acc),
        .shift_sel(rnd_shift),
        .acc_out  (rounded)
    );

    always_comb begin
        st_d = st_q;
        if (op_valid) begin
            case (op_code)
                OP_MUL_HI, OP_MUL_LO: st_d.acc = prod;
                OP_MAC_HI, OP_MAC_LO: st_d.acc = st_q.acc + prod;
                OP_ROUND:             st_d.acc = rounded;
                OP_WR_HI:             st_d.acc[ACC_W-1 -: OP_W] = opnd_a;
                OP_WR_LO:             st_d.acc[OP_W-1:0] = opnd_a;
                OP_RD_HI:             st_d.rd = st_q.acc[ACC_W-1 -: OP_W];
                OP_RD_MID:            st_d.rd = st_q.acc[MID_LSB +: OP_W];
                OP_RD_LO:             st_d.rd = st_q.acc[OP_W-1:0];
                default:              st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.rd;

    logic is_read;
    assign is_read = op_valid && ((op_code == OP_RD_HI) || (op_code == OP_RD_MID) ||
                                  (op_code == OP_RD_LO));

    p_mul_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == OP_MUL_HI || op_code == OP_MUL_LO))
        |=> st_q.acc == $past(prod));

    p_mac_add_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == OP_MAC_HI || op_code == OP_MAC_LO))
        |=> st_q.acc == $past(st_q.acc) + $past(prod));

    p_round_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_ROUND)
        |=> ($signed(st_q.acc) <= $signed(LIM_HI)) && ($signed(st_q.acc) >= $signed(LIM_LO)));

    p_round_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_ROUND) |=> st_q.acc[OP_W-1:0] == '0);

    p_wr_hi_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_WR_HI)
        |=> st_q.acc[OP_W-1:0] == $past(st_q.acc[OP_W-1:0]) &&
            st_q.acc[ACC_W-1 -: OP_W] == $past(opnd_a));

    p_rd_keep_acc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        is_read |=> $stable(st_q.acc));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(st_q.acc) && $stable(rd_data));

    p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !is_read |=> $stable(rd_data));

endmodule

// File: tb/test_mac_acc_unit.sv
module test_mac_acc_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [1:0]  rnd_shift = '0;
    logic [31:0] rd_data;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    longint      m_acc = 0;
    logic [31:0] m_rd  = '0;

    always #2.5 clk = ~clk;

    mac_acc_unit i_mac_acc_unit (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .op_code  (op_code),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .rnd_shift(rnd_shift),
        .rd_data  (rd_data)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fails++;
            $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    function automatic longint half_prod(bit hi, logic [31:0] a, logic [31:0] b);
        shortint x;
        shortint y;
        longint  p;
        x = hi ? a[31:16] : a[15:0];
        y = hi ? b[31:16] : b[15:0];
        p = longint'(x) * longint'(y);
        return p <<< 16;
    endfunction

    function automatic longint round_sat(longint acc, logic [1:0] s);
        longint t;
        t = (s == 2'd2) ? (acc <<< 2) : (acc <<< 1);
        t = t + 64'sh0000_0000_8000_0000;
        if (t > 64'sh0000_7FFF_0000_0000)
            t = 64'sh0000_7FFF_0000_0000;
        else if (t < 64'shFFFF_8000_0000_0000)
            t = 64'shFFFF_8000_0000_0000;
        t[31:0] = 32'h0;
        return t;
    endfunction

    task automatic model(logic v, logic [3:0] c, logic [31:0] a, logic [31:0] b, logic [1:0] s);
        if (v) begin
            case (c)
                4'd1:  m_acc = half_prod(1'b1, a, b);
                4'd2:  m_acc = half_prod(1'b0, a, b);
                4'd3:  m_acc = m_acc + half_prod(1'b1, a, b);
                4'd4:  m_acc = m_acc + half_prod(1'b0, a, b);
                4'd5:  m_acc = round_sat(m_acc, s);
                4'd6:  m_acc[63:32] = a;
                4'd7:  m_acc[31:0] = a;
                4'd8:  m_rd = m_acc[63:32];
                4'd9:  m_rd = m_acc[47:16];
                4'd10: m_rd = m_acc[31:0];
                default: ;
            endcase
        end
    endtask

    task automatic check(string tag, logic [31:0] exp);
        n_checks++;
        if (rd_data !== exp) begin
            n_fails++;
            $display("FAIL %s: rd_data=%h expected %h", tag, rd_data, exp);
        end
    endtask

    // Called at a falling edge: drive, let the rising edge pass, compare at the next falling edge.
    task automatic step(logic v, logic [3:0] c, logic [31:0] a, logic [31:0] b,
                        logic [1:0] s, string tag);
        op_valid  = v;
        op_code   = c;
        opnd_a    = a;
        opnd_b    = b;
        rnd_shift = s;
        @(posedge clk);
        model(v, c, a, b, s);
        @(negedge clk);
        check(tag, m_rd);
        op_valid = 1'b0;
    endtask

    task automatic peek(string tag);
        step(1'b1, 4'd8,  '0, '0, '0, tag);
        step(1'b1, 4'd9,  '0, '0, '0, tag);
        step(1'b1, 4'd10, '0, '0, '0, tag);
    endtask

    task automatic load(logic [31:0] hi, logic [31:0] lo, string tag);
        step(1'b1, 4'd6, hi, '0, '0, tag);
        step(1'b1, 4'd7, lo, '0, '0, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset read result", 32'h0);
        peek("R1 reset accumulator");

        step(1'b1, 4'd1, 32'h7FFF_1234, 32'h7FFF_ABCD, '0, "R2 mul upper max");
        peek("R2 mul upper max");
        step(1'b1, 4'd2, 32'h5555_8000, 32'h1111_8000, '0, "R2 mul lower min*min");
        peek("R2 mul lower min*min");
        step(1'b1, 4'd2, 32'h7777_FFFF, 32'h0000_0003, '0, "R2 mul lower negative");
        peek("R2 mul lower negative");
        step(1'b1, 4'd1, 32'h8000_0000, 32'h0002_FFFF, '0, "R2 mul upper negative");
        peek("R2 mul upper negative");

        step(1'b1, 4'd3, 32'h0100_0000, 32'h0200_0000, '0, "R3 mac upper");
        step(1'b1, 4'd4, 32'h0000_FFFE, 32'h0000_0005, '0, "R3 mac lower");
        peek("R3 mac sum");
        load(32'h7FFF_FFFF, 32'hFFFF_FFFF, "R7 preset for wrap");
        step(1'b1, 4'd4, 32'h0000_0001, 32'h0000_0001, '0, "R3 mac wrap");
        peek("R3 mac wrap");

        load(32'h0000_0012, 32'h4000_0000, "R7 preset round");
        step(1'b1, 4'd5, '0, '0, 2'd1, "R4 round shift 1");
        peek("R4 round shift 1");
        load(32'h0000_0012, 32'h4000_0000, "R7 preset round");
        step(1'b1, 4'd5, '0, '0, 2'd2, "R4 round shift 2");
        peek("R4 round shift 2");
        load(32'h0000_0012, 32'hC000_0000, "R7 preset round");
        step(1'b1, 4'd5, '0, '0, 2'd0, "R4 round code 0 as 1");
        peek("R4 round code 0 as 1");
        load(32'h0000_0012, 32'hC000_0000, "R7 preset round");
        step(1'b1, 4'd5, '0, '0, 2'd3, "R4 round code 3 as 1");
        peek("R4 round code 3 as 1");

        load(32'h0000_4000, 32'h0, "R7 preset sat");
        step(1'b1, 4'd5, '0, '0, 2'd2, "R5 clamp high");
        peek("R5 clamp high");
        load(32'h0000_3FFF, 32'hC000_0000, "R7 preset sat");
        step(1'b1, 4'd5, '0, '0, 2'd1, "R5 one past ceiling");
        peek("R5 one past ceiling");
        load(32'h0000_3FFF, 32'h4000_0000, "R7 preset sat");
        step(1'b1, 4'd5, '0, '0, 2'd1, "R5 exactly ceiling");
        peek("R5 exactly ceiling");
        load(32'hFFFF_C000, 32'h0, "R7 preset sat");
        step(1'b1, 4'd5, '0, '0, 2'd2, "R5 clamp low");
        peek("R5 clamp low");
        load(32'hC000_0000, 32'h0, "R7 preset sat");
        step(1'b1, 4'd5, '0, '0, 2'd1, "R5 shift overflow clamp low");
        peek("R5 shift overflow clamp low");
        load(32'h0000_0000, 32'hFFFF_FFFF, "R7 preset low word");
        step(1'b1, 4'd5, '0, '0, 2'd2, "R6 low word cleared");
        peek("R6 low word cleared");

        load(32'h1234_5678, 32'h9ABC_DEF0, "R7 write halves");
        peek("R8 read windows");
        step(1'b1, 4'd6, 32'hCAFE_F00D, '0, '0, "R7 write upper only");
        peek("R7 lower kept");
        step(1'b1, 4'd7, 32'h0BAD_BEEF, '0, '0, "R7 write lower only");
        peek("R7 upper kept");

        step(1'b1, 4'd8, '0, '0, '0, "R9 set read result");
        step(1'b0, 4'd1, 32'h7FFF_7FFF, 32'h7FFF_7FFF, '0, "R9 strobe low");
        step(1'b1, 4'd0, 32'h7FFF_7FFF, 32'h7FFF_7FFF, '0, "R9 code 0");
        for (int c = 11; c < 16; c++)
            step(1'b1, 4'(c), 32'h7FFF_7FFF, 32'h7FFF_7FFF, 2'd2, "R9 undefined code");
        peek("R9 accumulator unchanged");

        step(1'b1, 4'd1, 32'h0003_0000, 32'h0004_0000, '0, "R10 back to back");
        step(1'b1, 4'd9, '0, '0, '0, "R10 read right after mul");
        step(1'b1, 4'd3, 32'h0001_0000, 32'h0001_0000, '0, "R10 back to back");
        step(1'b1, 4'd9, '0, '0, '0, "R10 read right after mac");

        for (int i = 0; i < 400; i++)
            step($urandom_range(0, 7) != 0, 4'($urandom_range(0, 15)), $urandom, $urandom,
                 2'($urandom_range(0, 3)), "R10 mixed sequence");

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule